// File: doc/BRIEF.md
# Interrupt Pending-Bitmap Set/Clear Engine

This block serves software writes that mark a message-based interrupt as pending or no longer pending. Each such interrupt owns one bit of a bitmap held in memory. A write carries an interrupt number and a set-or-clear choice. The engine turns the number into a byte address and a bit position. It then reads that byte through a byte-wide memory port, changes the one bit, and writes the byte back. When the bitmap has really changed, it sends a single-cycle pulse that tells the priority logic to evaluate the pending interrupts again.

The register block supplies three settings: a global enable, the base address of the bitmap, and a number-width field. The width field sets the largest interrupt number in use. A request is dropped without any memory traffic when the enable is off or when the number is out of range. An accepted request reads the byte and decides in one cycle whether to write it back. If the bit already holds the requested value, there is no write and no pulse. Only one request is in flight at a time, and `req_ready` is low for all of it.

Top module: `lpi_pend_engine`

## Requirements
- R1: `req_ready` is high after reset and whenever the engine is idle. After an accepted request it is low from the next cycle until the notify cycle has passed. While it is low, a held `req_valid` is not taken.
- R2: A request presented while `lpi_en` is 0 is dropped. It causes no memory access and no pulse, and `req_ready` stays high in the next cycle.
- R3: The largest implemented number is 2^(w+1)-1, where w is `id_bits` clamped to at most 15. A request above that number is dropped in the same way as in R2. A request equal to that number is served.
- R4: The interrupt number is bits [31:0] of `req_data`. Bits [63:32] are ignored.
- R5: The byte address is `pend_base` plus the number shifted right by 3. The bit position is the number's low 3 bits, where 0 is the least significant bit of the byte.
- R6: A set request (`req_set`=1) whose bit already reads 1 is not written back and gives no pulse.
- R7: A clear request (`req_set`=0) whose bit already reads 0 is not written back and gives no pulse.
- R8: When the bit differs from the requested value, the byte is written back to the same address. The written byte differs from the byte read in exactly that one bit.
- R9: `prio_update` is high for exactly one cycle. That cycle directly follows the cycle in which the write-back is acknowledged, and there is no pulse in any other case.
- R10: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. Read data is taken in the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Set/clear register write strobe |
| req_set | input | 1 | 1 = mark pending, 0 = clear pending |
| req_data | input | 64 | Write data; the low 32 bits are the interrupt number |
| req_ready | output | 1 | Engine idle and able to take a request |
| lpi_en | input | 1 | Global enable from the register block |
| pend_base | input | 32 | Byte address of the pending bitmap |
| id_bits | input | 5 | Number-width setting (clamped to 15) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_ack | input | 1 | Access done; read data valid |
| mem_rdata | input | 8 | Byte read |
| prio_update | output | 1 | One-cycle request for a priority re-evaluation |

## Verification
Two functions can fall in the same cycle: the notify pulse that ends one request, and the presentation of the next request. The bench provokes this by keeping `req_valid` high with a second number right after the first request is taken. Whenever `prio_update` is high, `req_ready` must be low. The second request must start only after the pulse. The bench then checks that both bits end up in the shared byte and that exactly two pulses were seen.

// File: rtl/lpi_pend_pkg.sv
// Package: shared state encoding and helpers for the pending-bitmap engine.
// Assumes one request in flight at a time.
package lpi_pend_pkg;

    // Engine sequence states.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_MODIFY = 3'd2,
        ST_WRITE  = 3'd3,
        ST_NOTIFY = 3'd4
    } rmw_state_e;

    // Clamp the requested number width to the implemented maximum.
    function automatic logic [4:0] clamp_bits(input logic [4:0] req_bits,
                                              input logic [4:0] max_bits);
        return (req_bits > max_bits) ? max_bits : req_bits;
    endfunction

endpackage

// File: rtl/lpi_req_check.sv
// Module: lpi_req_check
// Decides whether a request is served and where its bit lives.
// Assumes MAX_ID_BITS + 1 < ID_W, so that the range limit fits in ID_W+1 bits.
module lpi_req_check
    import lpi_pend_pkg::*;
#(
    parameter int DATA_W      = 64,
    parameter int ID_W        = 32,
    parameter int ADDR_W      = 32,
    parameter int MAX_ID_BITS = 15
) (
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lpi_en,
    input  logic [4:0]        id_bits,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              in_range,
    output logic              serve_ok,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [2:0]        bit_pos
);
    localparam logic [4:0] MAX_BITS = 5'(MAX_ID_BITS);

    logic [ID_W-1:0] id_num;
    logic [4:0]      bits_eff;
    logic [5:0]      shift_amt;
    logic [ID_W:0]   id_limit;

    // Extract the number and compute the largest implemented value.
    always_comb begin
        id_num    = wr_data[ID_W-1:0];
        bits_eff  = clamp_bits(id_bits, MAX_BITS);
        shift_amt = {1'b0, bits_eff} + 6'd1;
        id_limit  = ({{ID_W{1'b0}}, 1'b1} << shift_amt) - {{ID_W{1'b0}}, 1'b1};
    end

    // Range and enable qualification.
    always_comb begin
        in_range = ({1'b0, id_num} <= id_limit);
        serve_ok = lpi_en && in_range;
    end

    // Byte address and bit position within the bitmap.
    always_comb begin
        byte_addr = base_addr + ADDR_W'(id_num >> 3);
        bit_pos   = id_num[2:0];
    end

endmodule

// File: rtl/lpi_bit_merge.sv
// Module: lpi_bit_merge
// Places the requested value into one bit of a byte and reports whether
// the byte changes. Purely combinational.
module lpi_bit_merge #(
    parameter int BYTE_W = 8,
    parameter int POS_W  = $clog2(BYTE_W)
) (
    input  logic [BYTE_W-1:0] old_byte,
    input  logic [POS_W-1:0]  pos,
    input  logic              want_set,
    output logic [BYTE_W-1:0] new_byte,
    output logic              changed
);
    // One lane per bit: replace the selected lane, keep the others.
    for (genvar g = 0; g < BYTE_W; g++) begin : g_lane
        assign new_byte[g] = (pos == POS_W'(g)) ? want_set : old_byte[g];
    end

    // The byte changes only if the selected bit differs from the request.
    always_comb changed = (old_byte[pos] != want_set);

endmodule

// File: rtl/lpi_rmw_seq.sv
// Module: lpi_rmw_seq
// Read-modify-write sequencer: idle, read, modify, write, notify.
// Assumes the memory holds mem_ack high for a single cycle per access.
module lpi_rmw_seq
    import lpi_pend_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 8,
    parameter int POS_W  = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_set,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [POS_W-1:0]  start_pos,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic [BYTE_W-1:0] merged_byte,
    input  logic              merge_changed,
    output logic              idle,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [POS_W-1:0]  cur_pos,
    output logic              cur_set,
    output logic              notify
);
    rmw_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] rd_q, wr_q;
    logic [POS_W-1:0]  pos_q;
    logic              set_q;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (start) state_d = ST_READ;
            ST_READ:   if (mem_ack) state_d = ST_MODIFY;
            ST_MODIFY: state_d = merge_changed ? ST_WRITE : ST_IDLE;
            ST_WRITE:  if (mem_ack) state_d = ST_NOTIFY;
            ST_NOTIFY: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            pos_q  <= '0;
            set_q  <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            addr_q <= start_addr;
            pos_q  <= start_pos;
            set_q  <= start_set;
        end
    end

    // Capture the read byte when the read is acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)                           rd_q <= '0;
        else if (state_q == ST_READ && mem_ack) rd_q <= mem_rdata;
    end

    // Hold the merged byte for the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                  wr_q <= '0;
        else if (state_q == ST_MODIFY) wr_q <= merged_byte;
    end

    // Drive the memory port and the status outputs.
    always_comb begin
        idle      = (state_q == ST_IDLE);
        mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = addr_q;
        mem_wdata = wr_q;
        rd_byte   = rd_q;
        cur_pos   = pos_q;
        cur_set   = set_q;
        notify    = (state_q == ST_NOTIFY);
    end

    // R10: the address does not move while an access waits for its ack.
    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R8: the byte written back differs from the byte read in one bit.
    assert_one_bit_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($countones(mem_wdata ^ rd_q) == 1));

endmodule

// File: rtl/lpi_pend_engine.sv
// Module: lpi_pend_engine (top)
// Serves set/clear-pending writes with a byte read-modify-write on the
// pending bitmap. It drops requests that are disabled or out of range, and
// pulses prio_update only when the bitmap really changes.
// Assumes a single-request memory port that answers every access with a
// one-cycle mem_ack.
module lpi_pend_engine #(
    parameter int DATA_W      = 64,
    parameter int ID_W        = 32,
    parameter int ADDR_W      = 32,
    parameter int BYTE_W      = 8,
    parameter int MAX_ID_BITS = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_set,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    input  logic              lpi_en,
    input  logic [ADDR_W-1:0] pend_base,
    input  logic [4:0]        id_bits,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              prio_update
);
    localparam int POS_W = $clog2(BYTE_W);

    logic              in_range, serve_ok, start, idle;
    logic [ADDR_W-1:0] chk_addr;
    logic [2:0]        chk_pos;
    logic [BYTE_W-1:0] rd_byte, merged_byte;
    logic [POS_W-1:0]  cur_pos;
    logic              cur_set, merge_changed;

    lpi_req_check #(
        .DATA_W(DATA_W), .ID_W(ID_W), .ADDR_W(ADDR_W), .MAX_ID_BITS(MAX_ID_BITS)
    ) u_check (
        .wr_data  (req_data),
        .lpi_en   (lpi_en),
        .id_bits  (id_bits),
        .base_addr(pend_base),
        .in_range (in_range),
        .serve_ok (serve_ok),
        .byte_addr(chk_addr),
        .bit_pos  (chk_pos)
    );

    // A request starts only when idle and qualified.
    always_comb start = req_valid && idle && serve_ok;

    lpi_rmw_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .POS_W(POS_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_set    (req_set),
        .start_addr   (chk_addr),
        .start_pos    (POS_W'(chk_pos)),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .merged_byte  (merged_byte),
        .merge_changed(merge_changed),
        .idle         (idle),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .rd_byte      (rd_byte),
        .cur_pos      (cur_pos),
        .cur_set      (cur_set),
        .notify       (prio_update)
    );

    lpi_bit_merge #(.BYTE_W(BYTE_W), .POS_W(POS_W)) u_merge (
        .old_byte(rd_byte),
        .pos     (cur_pos),
        .want_set(cur_set),
        .new_byte(merged_byte),
        .changed (merge_changed)
    );

    // Ready mirrors the idle state.
    always_comb req_ready = idle;

    // R1: an accepted request takes the engine busy and starts a read.
    assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && serve_ok) |=> (!req_ready && mem_req && !mem_we));

    // R2: a disabled request leaves the engine idle.
    assert_disabled_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !lpi_en) |=> (req_ready && !mem_req));

    // R3: an out-of-range request leaves the engine idle.
    assert_range_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !in_range) |=> (req_ready && !mem_req));

    // R9: the pulse lasts one cycle and follows a write acknowledge.
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prio_update |=> !prio_update);
    assert_pulse_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prio_update) |-> $past(mem_req && mem_we && mem_ack));

endmodule

// File: tb/lpi_pend_engine_test.sv
// Bench for lpi_pend_engine: a vector table walked by one loop, then
// directed tests for reset, memory latency and back-to-back requests.
module lpi_pend_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_set = 1'b0, lpi_en = 1'b0;
    logic [63:0] req_data = '0;
    logic [31:0] pend_base = BASE;
    logic [4:0]  id_bits = 5'd7;
    logic        req_ready, mem_req, mem_we, prio_update;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;

    int tests = 0, fails = 0;
    int wr_cnt = 0, pulse_cnt = 0, pulse_err = 0, clash = 0;
    int lat = 0, wait_cnt = 0, cycles = 0;
    logic wack_prev = 1'b0;
    logic [7:0] mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    lpi_pend_engine uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set),
        .req_data(req_data), .req_ready(req_ready), .lpi_en(lpi_en),
        .pend_base(pend_base), .id_bits(id_bits), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .prio_update(prio_update)
    );

    // Memory model with programmable latency, plus pulse-timing monitor.
    always @(negedge clk) begin
        logic wack_now;
        wack_now = 1'b0;
        if (prio_update) pulse_cnt++;
        if (prio_update && req_ready) clash++;
        if (wack_prev != prio_update) pulse_err++;
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_ack  = 1'b1;
                wait_cnt = 0;
                if (mem_we) begin
                    mem[mem_addr[7:0]] = mem_wdata;
                    wr_cnt++;
                    wack_now = 1'b1;
                end else mem_rdata = mem[mem_addr[7:0]];
            end else wait_cnt++;
        end
        wack_prev = wack_now;
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 60 && !req_ready; i++) begin
            @(negedge clk); #1;
        end
    endtask

    typedef struct packed {
        logic        set;
        logic        en;
        logic [4:0]  bits;
        logic [63:0] data;
        logic        acc;
        logic        chg;
    } vec_t;

    // Bitmap bytes start at 8'hA5. Expected outcomes follow the listed order.
    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 5'd7,  64'd9,                 1'b1, 1'b1}, // R8 set clear bit
        '{1'b1, 1'b1, 5'd7,  64'd9,                 1'b1, 1'b0}, // R6 already set
        '{1'b0, 1'b1, 5'd7,  64'd9,                 1'b1, 1'b1}, // R8 clear set bit
        '{1'b0, 1'b1, 5'd7,  64'd9,                 1'b1, 1'b0}, // R7 already clear
        '{1'b1, 1'b1, 5'd7,  64'd10,                1'b1, 1'b0}, // R6 preset bit
        '{1'b0, 1'b1, 5'd7,  64'd16,                1'b1, 1'b1}, // R5 next byte bit0
        '{1'b1, 1'b0, 5'd7,  64'd11,                1'b0, 1'b0}, // R2 disabled
        '{1'b0, 1'b1, 5'd7,  64'd255,               1'b1, 1'b1}, // R3 at limit
        '{1'b0, 1'b1, 5'd7,  64'd256,               1'b0, 1'b0}, // R3 above limit
        '{1'b1, 1'b1, 5'd7,  64'hFFFF_FFFF_0000_000C, 1'b1, 1'b1}, // R4 upper ignored
        '{1'b1, 1'b1, 5'd20, 64'd300,               1'b1, 1'b1}, // R3 clamp in range
        '{1'b1, 1'b1, 5'd31, 64'd70000,             1'b0, 1'b0}, // R3 clamp drop
        '{1'b0, 1'b1, 5'd15, 64'd65535,             1'b1, 1'b1}  // R3 clamp limit
    };

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hA5;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check("R1 ready after reset", req_ready, 1);
        check("R9 no pulse after reset", prio_update, 0);
        check("R10 no access after reset", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;

        for (int v = 0; v < NV; v++) begin
            int w0, p0, idx;
            logic [31:0] id;
            logic [7:0] oldb, expb;
            id   = VEC[v].data[31:0];
            idx  = int'((BASE + (id >> 3)) & 32'hFF);
            oldb = mem[idx];
            expb = oldb;
            if (VEC[v].chg) expb[id[2:0]] = VEC[v].set;
            w0 = wr_cnt; p0 = pulse_cnt;
            lpi_en = VEC[v].en; id_bits = VEC[v].bits;
            req_set = VEC[v].set; req_data = VEC[v].data; req_valid = 1'b1;
            @(negedge clk); #1;
            req_valid = 1'b0;
            check($sformatf("R1 R2 R3 ready after accept v%0d", v), req_ready, !VEC[v].acc);
            wait_idle();
            @(negedge clk); #1;
            check($sformatf("R6 R7 R8 write count v%0d", v), wr_cnt - w0, VEC[v].chg);
            check($sformatf("R9 pulse count v%0d", v), pulse_cnt - p0, VEC[v].chg);
            check($sformatf("R5 R8 byte value v%0d", v), mem[idx], expb);
        end

        // R10: slow memory, three wait cycles per access
        lat = 3;
        lpi_en = 1'b1; id_bits = 5'd7;
        req_set = 1'b1; req_data = 64'd17; req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
        wait_idle();
        @(negedge clk); #1;
        check("R10 slow memory byte", mem[8'h22], 8'hA4 | 8'h02);

        // R1/R9 back-to-back: second request held during the notify cycle
        lat = 0;
        begin
            int p0;
            p0 = pulse_cnt;
            req_set = 1'b1; req_data = 64'd1; req_valid = 1'b1;
            @(negedge clk); #1;
            check("R1 busy after first accept", req_ready, 0);
            req_data = 64'd3;
            for (int i = 0; i < 60 && !req_ready; i++) begin
                @(negedge clk); #1;
            end
            @(negedge clk); #1;
            req_valid = 1'b0;
            wait_idle();
            @(negedge clk); #1;
            check("R1 ready low during notify", clash, 0);
            check("R9 two pulses back to back", pulse_cnt - p0, 2);
            check("R8 both bits in shared byte", mem[8'h20], 8'hAF);
        end

        check("R9 pulse timing versus write ack", pulse_err, 0);
        check("R1 idle at end", req_ready, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule